// File: doc/BRIEF.md
# Three-Port Parallel I/O with Single-Bit Port C Control

This block is a parallel I/O peripheral with three byte-wide ports, called A, B and C, reached by a processor through a small register interface. A two-bit address selects one of the three port data registers or the control register. The interface also has an 8-bit write bus, a write strobe, a read strobe and a registered read-data bus. Each port drives an output latch and an output-enable vector toward its pins and takes a pin-sample vector back. Port C is split into an upper and a lower nibble, and each nibble has its own direction.

The control register address takes two kinds of word, told apart by bit 7. When bit 7 is 1 the word sets the port directions and modes. The mode fields are stored and read back, but every port behaves as a simple latched port whatever mode is written. When bit 7 is 0 the word is a command that sets or clears one bit of the port C latch, and the stored configuration is left alone. Because of this, software can toggle single port C lines without first reading the port back.

Top module: `ppio_top`

## Requirements
- R1: After reset, every output-enable is 0, every output latch is 0, and a read of the control register (address 3) returns 9Bh.
- R2: A write to address 3 with bit 7 = 1 stores bits 6..0 as the configuration. The direction bits are: bit 4 for port A, bit 3 for the upper nibble of port C, bit 1 for port B and bit 0 for the lower nibble of port C. A direction bit of 1 means input, which gives output-enable 0. A direction bit of 0 means output, which gives output-enable all ones. These take effect on the clock edge of the write. The word 80h makes every port an output.
- R3: A configuration write clears the A, B and C output latches to zero on the same edge.
- R4: A write to address 0, 1 or 2 loads the port A, B or C latch on that edge, whatever the port's direction. The other latches do not change.
- R5: A read strobe captures the data on its clock edge, and rdata presents it from that edge on. rdata holds its value until the next read strobe.
- R6: A read of a port returns the latch when the port is an output and the pin samples when it is an input. Port C is resolved nibble by nibble, using the direction of each nibble.
- R7: A write to address 3 with bit 7 = 0 is a bit command. Bits 3..1 select the port C bit and bit 0 gives its new value. Only that latch bit may change, and ports A and B are untouched. For example, 0Bh sets bit 5 of port C.
- R8: A bit command leaves the stored configuration unchanged. A later read of address 3 returns the last configuration word.
- R9: A bit command aimed at an input nibble of port C updates that latch bit on pc_out. pc_oe does not change.
- R10: Mode fields (bits 6..5 for port A, bit 2 for port B) are stored and read back with bit 7 set. They have no effect on the output-enables or on the latch behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin samples |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output-enable |
| pb_in | input | 8 | Port B pin samples |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output-enable |
| pc_in | input | 8 | Port C pin samples |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output-enable, per nibble |

## Verification
Every write result is due on the clock edge that takes the strobe. This covers latch loads, latch clears, single-bit changes and output-enable changes. A read result appears on rdata at the edge that takes the read strobe and stays there until the next read. The bench drives each strobe at a falling edge and takes it away at the next falling edge, so exactly one rising edge sees it. It compares the outputs at that same falling edge, half a cycle after the result is due. Pin samples are driven before the strobe and held across the edge, so the expected value of an input read is known at that edge.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // stored configuration, bit 7 of the control word is implied
    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    localparam int CTRL_W   = 8;
    localparam int KIND_BIT = 7;

endpackage

// File: rtl/ppio_cfg.sv
module ppio_cfg
    import ppio_pkg::*;
#(
    parameter int PW = 8,
    localparam int SW = $clog2(PW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              mode_wr,
    output logic              bsr_wr,
    output logic [SW-1:0]     bsr_sel,
    output logic              bsr_val
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t cur_q, nxt_d;

    always_comb begin
        mode_wr = wr_ctrl &&  wdata[KIND_BIT];
        bsr_wr  = wr_ctrl && !wdata[KIND_BIT];
        bsr_sel = wdata[SW:1];
        bsr_val = wdata[0];
        nxt_d   = cur_q;
        if (mode_wr) begin
            nxt_d.cfg = cfg_t'(wdata[KIND_BIT-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cfg <= CFG_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cfg = cur_q.cfg;

    AST_BSR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[KIND_BIT]) |=> $stable(cur_q.cfg)); // R8

    AST_MODE_WORD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[KIND_BIT]) |=> (cur_q.cfg == $past(wdata[KIND_BIT-1:0]))); // R10

endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
    parameter int PW      = 8,
    parameter int HAS_BIT = 0,
    localparam int SW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [PW-1:0] ld_data,
    input  logic          bit_en,
    input  logic [SW-1:0] bit_sel,
    input  logic          bit_val,
    output logic [PW-1:0] q
);

    typedef struct packed {
        logic [PW-1:0] q;
    } state_t;

    state_t        cur_q, nxt_d;
    logic          bit_go;
    logic [PW-1:0] bit_mask;

    generate
        if (HAS_BIT != 0) begin : g_bit
            assign bit_go   = bit_en;
            assign bit_mask = {{(PW-1){1'b0}}, 1'b1} << bit_sel;
        end else begin : g_nobit
            assign bit_go   = 1'b0;
            assign bit_mask = {PW{1'b0}};
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d.q = '0;
        end else if (ld) begin
            nxt_d.q = ld_data;
        end else if (bit_go) begin
            nxt_d.q = bit_val ? (cur_q.q | bit_mask) : (cur_q.q & ~bit_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign q = cur_q.q;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R3

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !ld) |=> ($countones(q ^ $past(q)) <= 1)); // R7

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (q == $past(ld_data))); // R4

endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
    import ppio_pkg::*;
#(
    parameter int PW = 8,
    localparam int NIB = PW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  cfg_t          cfg,
    input  logic [PW-1:0] la,
    input  logic [PW-1:0] lb,
    input  logic [PW-1:0] lc,
    input  logic [PW-1:0] pa_in,
    input  logic [PW-1:0] pb_in,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] rdata
);

    typedef struct packed {
        logic [PW-1:0] rdata;
    } state_t;

    state_t        cur_q, nxt_d;
    logic [PW-1:0] a_view, b_view, c_view, ctrl_view;

    always_comb begin
        a_view    = cfg.a_in ? pa_in : la;
        b_view    = cfg.b_in ? pb_in : lb;
        c_view    = {cfg.cu_in ? pc_in[PW-1:NIB] : lc[PW-1:NIB],
                     cfg.cl_in ? pc_in[NIB-1:0]  : lc[NIB-1:0]};
        ctrl_view = PW'({1'b1, cfg});
        nxt_d     = cur_q;
        if (rd_en) begin
            unique case (reg_sel_e'(addr))
                SEL_A:    nxt_d.rdata = a_view;
                SEL_B:    nxt_d.rdata = b_view;
                SEL_C:    nxt_d.rdata = c_view;
                SEL_CTRL: nxt_d.rdata = ctrl_view;
                default:  nxt_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.rdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata = cur_q.rdata;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R5

    AST_INPUT_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && cfg.a_in) |=> (rdata == $past(pa_in))); // R6

endmodule

// File: rtl/ppio_top.sv
module ppio_top
    import ppio_pkg::*;
#(
    parameter int PW = 8,
    localparam int SW    = $clog2(PW),
    localparam int NIB   = PW / 2,
    localparam int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [7:0]    rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);

    cfg_t          cfg;
    logic          mode_wr, bsr_wr, bsr_val;
    logic [SW-1:0] bsr_sel;
    logic          wr_ctrl;
    logic [PW-1:0] lat_q [NPORT];

    assign wr_ctrl = wr_en && (reg_sel_e'(addr) == SEL_CTRL);

    ppio_cfg #(.PW(PW)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
        .cfg(cfg), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
        .bsr_sel(bsr_sel), .bsr_val(bsr_val)
    );

    generate
        for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
            ppio_latch #(.PW(PW), .HAS_BIT((gi == 2) ? 1 : 0)) lat_i (
                .clk(clk), .rst_n(rst_n),
                .clr(mode_wr),
                .ld(wr_en && (addr == 2'(gi))),
                .ld_data(wdata[PW-1:0]),
                .bit_en(bsr_wr),
                .bit_sel(bsr_sel),
                .bit_val(bsr_val),
                .q(lat_q[gi])
            );
        end
    endgenerate

    assign pa_out = lat_q[0];
    assign pb_out = lat_q[1];
    assign pc_out = lat_q[2];
    assign pa_oe  = {PW{~cfg.a_in}};
    assign pb_oe  = {PW{~cfg.b_in}};
    assign pc_oe  = {{NIB{~cfg.cu_in}}, {NIB{~cfg.cl_in}}};

    ppio_rdmux #(.PW(PW)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cfg(cfg),
        .la(lat_q[0]), .lb(lat_q[1]), .lc(lat_q[2]),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .rdata(rdata)
    );

    AST_DIR_A_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[7]) |=> (pa_oe == {PW{~$past(wdata[4])}})); // R2

    AST_BSR_SPARES_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[7]) |=> ($stable(pa_out) && $stable(pb_out))); // R7

    AST_BSR_OE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[7]) |=> $stable(pc_oe)); // R9

    AST_MODE_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R3

endmodule

// File: tb/ppio_top_tb_top.sv
module ppio_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    // bench model
    logic [7:0] m_cfg = 8'h9B;
    logic [7:0] m_la = '0, m_lb = '0, m_lc = '0;
    logic [7:0] m_rd = '0;

    always #4 clk = ~clk;

    ppio_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return m_cfg[4] ? pa_in : m_la;
            2'd1: return m_cfg[1] ? pb_in : m_lb;
            2'd2: return {m_cfg[3] ? pc_in[7:4] : m_lc[7:4],
                          m_cfg[0] ? pc_in[3:0] : m_lc[3:0]};
            default: return m_cfg;
        endcase
    endfunction

    task automatic check_pins(string req);
        check({req, " pa_out"}, pa_out, m_la);
        check({req, " pb_out"}, pb_out, m_lb);
        check({req, " pc_out"}, pc_out, m_lc);
        check({req, " pa_oe"}, pa_oe, {8{~m_cfg[4]}});
        check({req, " pb_oe"}, pb_oe, {8{~m_cfg[1]}});
        check({req, " pc_oe"}, pc_oe, {{4{~m_cfg[3]}}, {4{~m_cfg[0]}}});
    endtask

    task automatic do_write(logic [1:0] a, logic [7:0] d, string req);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd3 && d[7]) begin
            m_cfg = d; m_la = '0; m_lb = '0; m_lc = '0;
        end else if (a == 2'd3) begin
            m_lc[d[3:1]] = d[0];
        end else if (a == 2'd0) m_la = d;
        else if (a == 2'd1) m_lb = d;
        else m_lc = d;
        check_pins(req);
        check({req, " rdata held"}, rdata, m_rd);
    endtask

    task automatic do_read(logic [1:0] a, string req);
        addr = a; rd_en = 1'b1;
        m_rd = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rdata"}, rdata, m_rd);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_pins("R1");
        do_read(2'd3, "R1 ctrl");
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h3C;
        do_read(2'd0, "R6 A input");
        do_read(2'd2, "R6 C input");
        // R2 all outputs, R4 loads
        do_write(2'd3, 8'h80, "R2 80h");
        do_write(2'd0, 8'hA5, "R4 A");
        do_write(2'd1, 8'h96, "R4 B");
        do_write(2'd2, 8'h10, "R4 C");
        do_read(2'd1, "R6 B output");
        // R7 0Bh sets bit 5
        do_write(2'd3, 8'h0B, "R7 0Bh");
        check("R7 bit5", pc_out, 8'h30);
        do_write(2'd3, 8'h08, "R7 clear bit4");
        // R8 cfg unchanged
        do_read(2'd3, "R8 ctrl after bsr");
        // R3 mode write clears
        do_write(2'd3, 8'h88, "R3 clear");
        // R9 BSR on input upper nibble
        do_write(2'd3, 8'h0F, "R9 bsr input nibble");
        check("R9 pc_oe", pc_oe, 8'h0F);
        do_read(2'd2, "R6 C mixed");
        // R10 mode fields
        do_write(2'd3, 8'hE6, "R10 modes");
        do_read(2'd3, "R10 ctrl");
        // R4 write to input port still loads latch
        do_write(2'd1, 8'h3E, "R4 B input");
        do_read(2'd1, "R6 B pins");
        // R5 hold across idle cycles
        @(negedge clk);
        check("R5 hold", rdata, m_rd);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            case (op)
                0: do_write(2'd3, {1'b1, 7'($urandom)}, "R2 rnd mode");
                1: do_write(2'd3, {4'b0000, 4'($urandom)}, "R7 rnd bsr");
                2: do_write(2'($urandom_range(0, 2)), 8'($urandom), "R4 rnd");
                default: do_read(2'($urandom), "R6 rnd read");
            endcase
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule